// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces, once per phase-detector cycle, the whole-number ratio loaded into the feedback divider of a fractional-N synthesizer. Software supplies an integer part, a fraction numerator, a denominator (the modulus) and an order code. The block returns a sequence of neighbouring integers. Averaged over time, that sequence equals the integer part plus numerator divided by modulus. The synthesized frequency is then the phase-detector rate times that average.

The block is a chain of up to four accumulators. Each one wraps at the programmed modulus, so the denominator need not be a power of two. Every accumulator after the first adds in the residue of the stage before it. A combining network takes the overflow carries of the enabled stages and their delayed copies and forms a signed correction. That correction is added to the integer part. A higher order pushes the quantization error further from the carrier, at the cost of a wider spread of instantaneous ratios. The block advances only on a tick strobe. The result appears one clock later, together with a one-cycle valid flag. The numerator is expected to be below the modulus, and the integer part is expected to be large enough that the lowest corrected ratio stays positive.

Top module: `fracn_mash`

## Requirements
- R1: Each clock with `pfd_tick` high is followed one clock later by `div_valid` high for one clock, showing the new ratio on `div_val`. A clock without a tick is followed by `div_valid` low, and `div_val` is held unchanged.
- R2: With `order_sel` = 0 (first order), every output is N or N+1. After t ticks from a fresh start, the number of N+1 outputs equals floor(t·Frac/Modulus). For example, N=60, Frac=3, Modulus=51 gives 48 outputs of 60 and 3 outputs of 61 in 51 ticks.
- R3: With `order_sel` = 1 (second order), outputs lie in N−1..N+2. After t ticks from a fresh start, the running sum of (output − N) minus floor(t·Frac/Modulus) lies in 0..1. Consequently, the sum over exactly Modulus ticks equals N·Modulus+Frac; with N=142, Frac=22, Modulus=199 it is 28280.
- R4: With `order_sel` = 2 (third order), outputs lie in the eight values N−3..N+4. The running-sum excess defined in R3 lies in −1..2.
- R5: With `order_sel` = 3 (fourth order), outputs lie in N−7..N+8. The running-sum excess lies in −3..4.
- R6: With Frac = 0, every output from a fresh start equals N exactly, for every order.
- R7: Any modulus from 1 to 4194303 (2^22−1) is accepted, and R2 to R5 hold at the top of that range.
- R8: A tick at which `modulus` or `order_sel` differs from the values applied at the previous tick clears all accumulators and carry history first. That tick then behaves as the first tick after reset.
- R9: A change of `int_n` or `frac_num` alone takes effect at the next tick without clearing the accumulators.
- R10: While `rst_n` is low, `div_valid` is 0, `div_val` is 0 and all accumulator state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfd_tick | input | 1 | One pulse per phase-detector cycle; advances the modulator |
| int_n | input | INT_W (16) | Integer part of the divide ratio |
| frac_num | input | MOD_W (22) | Fraction numerator, below `modulus` |
| modulus | input | MOD_W (22) | Fraction denominator, 1 to 2^MOD_W−1 |
| order_sel | input | 2 | 0: first, 1: second, 2: third, 3: fourth order |
| div_val | output | INT_W (16) | Instantaneous divide ratio |
| div_valid | output | 1 | High one clock after each tick |

## Verification
A vector table runs each order over several cases. The first is the 60 + 3/51 case, where the carry count is exact. The second is 142 + 22/199, whose full-period sum is exact for the lower orders. The others are a zero numerator, a modulus near 2^22 with numerators both near the modulus and at 1, and a tiny modulus of 2. Together these separate a wrong wrap point, a wrong carry-combination coefficient, and a stage that is enabled when it should not be. On every tick, the instantaneous spread and the running-sum excess against floor(t·Frac/Modulus) are compared with the bounds for that order. Directed runs then change the modulus or the order in mid-sequence, and change the integer part on its own. In each case the first carry lands on a different tick depending on whether the accumulators were cleared.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;

    // Number of accumulator stages built; the highest order needs all of them.
    localparam int STAGES = 4;
    // Delayed carries kept per stage (stage k uses k of them).
    localparam int HIST = STAGES - 1;
    // Width of the signed correction: spans -(2^(STAGES-1)-1) .. 2^(STAGES-1).
    localparam int CORR_W = STAGES + 1;

    typedef enum logic [1:0] {
        ORD_FIRST  = 2'd0,
        ORD_SECOND = 2'd1,
        ORD_THIRD  = 2'd2,
        ORD_FOURTH = 2'd3
    } order_e;

    // Binomial coefficient; zero outside 0..n.
    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        if (k < 0 || k > n) return 0;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    // Weight of the carry of stage s delayed by d ticks: (-1)^d * C(s, d).
    function automatic int carry_weight(input int s, input int d);
        return ((d % 2) == 1) ? -binom(s, d) : binom(s, d);
    endfunction

endpackage

// File: rtl/fracn_mod_acc.sv
`timescale 1ns/1ps
// One accumulator stage that wraps at an arbitrary modulus.
module fracn_mod_acc #(
    parameter int W = 22
) (
    input  logic         en,
    input  logic [W-1:0] acc_q,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] acc_d,
    output logic         carry
);
    logic [W:0] sum;
    logic [W:0] wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, addend};
        wrapped = sum - {1'b0, modulus};
        carry   = 1'b0;
        acc_d   = '0;
        if (en) begin
            if (sum >= {1'b0, modulus}) begin
                carry = 1'b1;
                acc_d = wrapped[W-1:0];
            end else begin
                acc_d = sum[W-1:0];
            end
        end
    end
endmodule

// File: rtl/fracn_carry_combine.sv
`timescale 1ns/1ps
// Forms the signed correction from current and delayed carries:
// stage s contributes the s-th backward difference of its carry stream.
module fracn_carry_combine
    import fracn_pkg::*;
(
    input  logic [STAGES-1:0]           carry,
    input  logic [STAGES-1:0][HIST-1:0] hist,
    output logic signed [CORR_W-1:0]    corr
);
    int total;
    int bit_v;

    always_comb begin
        total = 0;
        for (int s = 0; s < STAGES; s++) begin
            for (int d = 0; d <= HIST; d++) begin
                bit_v = (d == 0) ? int'(carry[s]) : int'(hist[s][d-1]);
                total = total + carry_weight(s, d) * bit_v;
            end
        end
        corr = total[CORR_W-1:0];
    end
endmodule

// File: rtl/fracn_mash.sv
`timescale 1ns/1ps
module fracn_mash
    import fracn_pkg::*;
#(
    parameter int INT_W = 16,
    parameter int MOD_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_tick,
    input  logic [INT_W-1:0] int_n,
    input  logic [MOD_W-1:0] frac_num,
    input  logic [MOD_W-1:0] modulus,
    input  logic [1:0]       order_sel,
    output logic [INT_W-1:0] div_val,
    output logic             div_valid
);
    localparam int SUM_W = INT_W + 2;

    typedef struct packed {
        logic [STAGES-1:0][MOD_W-1:0] acc;
        logic [STAGES-1:0][HIST-1:0]  hist;
        logic [MOD_W-1:0]             mod_app;
        logic [1:0]                   ord_app;
        logic [INT_W-1:0]             val;
        logic                         vld;
    } state_t;

    state_t st_d, st_q;

    logic                           restart;
    logic [STAGES-1:0][MOD_W-1:0]   acc_base;
    logic [STAGES-1:0][HIST-1:0]    hist_base;
    logic [MOD_W-1:0]               acc_new [STAGES];
    logic [MOD_W-1:0]               addend  [STAGES];
    logic [STAGES-1:0]              carry;
    logic [STAGES-1:0]              stage_en;
    logic signed [CORR_W-1:0]       corr;
    logic signed [SUM_W-1:0]        ratio;

    // A new modulus or order invalidates the residues: start from zero.
    assign restart   = (modulus != st_q.mod_app) || (order_sel != st_q.ord_app);
    assign acc_base  = restart ? '0 : st_q.acc;
    assign hist_base = restart ? '0 : st_q.hist;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stage_en[k] = (k <= int'(order_sel));
        if (k == 0) begin : g_head
            assign addend[k] = frac_num;
        end else begin : g_tail
            assign addend[k] = acc_new[k-1];
        end
        fracn_mod_acc #(.W(MOD_W)) u_acc (
            .en      (stage_en[k]),
            .acc_q   (acc_base[k]),
            .addend  (addend[k]),
            .modulus (modulus),
            .acc_d   (acc_new[k]),
            .carry   (carry[k])
        );
    end

    fracn_carry_combine u_comb (
        .carry (carry),
        .hist  (hist_base),
        .corr  (corr)
    );

    assign ratio = $signed({2'b00, int_n}) + {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (pfd_tick) begin
            for (int k = 0; k < STAGES; k++) begin
                st_d.acc[k]  = acc_new[k];
                st_d.hist[k] = {hist_base[k][HIST-2:0], carry[k]};
            end
            st_d.mod_app = modulus;
            st_d.ord_app = order_sel;
            st_d.val     = ratio[INT_W-1:0];
            st_d.vld     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_val   = st_q.val;
    assign div_valid = st_q.vld;
endmodule

// File: rtl/fracn_mash_chk.sv
`timescale 1ns/1ps
module fracn_mash_chk #(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pfd_tick,
    input logic [INT_W-1:0] int_n,
    input logic [1:0]       order_sel,
    input logic [INT_W-1:0] div_val,
    input logic             div_valid
);
    a_r1_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        pfd_tick |=> div_valid);

    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !pfd_tick |=> (!div_valid && $stable(div_val)));

    a_r2_first_order_span: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_tick && order_sel == 2'd0) |=>
        ((int'(div_val) - int'($past(int_n))) >= 0 &&
         (int'(div_val) - int'($past(int_n))) <= 1));

    a_r3_second_order_span: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_tick && order_sel == 2'd1) |=>
        ((int'(div_val) - int'($past(int_n))) >= -1 &&
         (int'(div_val) - int'($past(int_n))) <= 2));

    a_r4_third_order_span: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_tick && order_sel == 2'd2) |=>
        ((int'(div_val) - int'($past(int_n))) >= -3 &&
         (int'(div_val) - int'($past(int_n))) <= 4));

    a_r5_fourth_order_span: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_tick && order_sel == 2'd3) |=>
        ((int'(div_val) - int'($past(int_n))) >= -7 &&
         (int'(div_val) - int'($past(int_n))) <= 8));

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!div_valid && div_val == '0));
endmodule

bind fracn_mash fracn_mash_chk #(.INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfd_tick  (pfd_tick),
    .int_n     (int_n),
    .order_sel (order_sel),
    .div_val   (div_val),
    .div_valid (div_valid)
);

// File: tb/fracn_mash_bench.sv
`timescale 1ns/1ps
module fracn_mash_bench;
    localparam int INT_W = 16;
    localparam int MOD_W = 22;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pfd_tick = 1'b0;
    logic [INT_W-1:0] int_n = '0;
    logic [MOD_W-1:0] frac_num = '0;
    logic [MOD_W-1:0] modulus = '0;
    logic [1:0]       order_sel = '0;
    logic [INT_W-1:0] div_val;
    logic             div_valid;

    always #2.5 clk = ~clk;

    fracn_mash #(.INT_W(INT_W), .MOD_W(MOD_W)) u_fracn_mash (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .int_n(int_n),
        .frac_num(frac_num), .modulus(modulus), .order_sel(order_sel),
        .div_val(div_val), .div_valid(div_valid)
    );

    typedef struct packed {
        logic [15:0] n;
        logic [21:0] f;
        logic [21:0] m;
        logic [1:0]  ord;
        logic [15:0] ticks;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{16'd60,  22'd3,       22'd51,      2'd0, 16'd51},   // R2 example
        '{16'd142, 22'd22,      22'd199,     2'd1, 16'd199},  // R3 example
        '{16'd142, 22'd22,      22'd199,     2'd2, 16'd199},  // R4
        '{16'd142, 22'd22,      22'd199,     2'd3, 16'd199},  // R5
        '{16'd100, 22'd54,      22'd199,     2'd2, 16'd300},  // R4
        '{16'd100, 22'd54,      22'd199,     2'd3, 16'd300},  // R5
        '{16'd500, 22'd0,       22'd400,     2'd0, 16'd40},   // R6
        '{16'd500, 22'd0,       22'd400,     2'd1, 16'd40},   // R6
        '{16'd500, 22'd0,       22'd400,     2'd3, 16'd40},   // R6
        '{16'd300, 22'd4194302, 22'd4194303, 2'd0, 16'd200},  // R7
        '{16'd300, 22'd4194302, 22'd4194303, 2'd1, 16'd200},  // R7
        '{16'd300, 22'd1,       22'd4194303, 2'd3, 16'd200},  // R7
        '{16'd40,  22'd1,       22'd2,       2'd3, 16'd64},   // R5
        '{16'd60,  22'd3,       22'd51,      2'd2, 16'd102}   // R4
    };

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        pfd_tick = 1'b0;
        repeat (2) @(negedge clk);
        check(div_valid == 1'b0 && div_val == '0, "R10", longint'(div_val), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One tick: result and valid appear after the next rising edge;
    // a clock later valid must drop and the value must be held.
    task automatic do_tick(output int v);
        pfd_tick = 1'b1;
        @(negedge clk);
        pfd_tick = 1'b0;
        v = int'(div_val);
        check(div_valid == 1'b1, "R1", longint'(div_valid), 1);
        @(negedge clk);
        check(div_valid == 1'b0 && int'(div_val) == v, "R1", longint'(div_val), longint'(v));
    endtask

    function automatic string span_req(input vec_t vv);
        if (vv.f == 0)         return "R6";
        if (vv.m > 22'd65535)  return "R7";
        case (vv.ord)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic int cum_lo(input logic [1:0] o);
        case (o) 2'd0: return 0; 2'd1: return 0; 2'd2: return -1; default: return -3; endcase
    endfunction

    function automatic int cum_hi(input logic [1:0] o);
        case (o) 2'd0: return 0; 2'd1: return 1; 2'd2: return 2; default: return 4; endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        longint cum;
        longint base;
        int dev;
        int lo;
        int hi;
        string rq;

        // Vector table: spread and running-sum bounds per order (R2..R7).
        for (int i = 0; i < NVEC; i++) begin
            int_n     = VECS[i].n;
            frac_num  = VECS[i].f;
            modulus   = VECS[i].m;
            order_sel = VECS[i].ord;
            do_reset();
            rq  = span_req(VECS[i]);
            cum = 0;
            lo  = 1 - (1 << VECS[i].ord);
            hi  = 1 << VECS[i].ord;
            for (int t = 1; t <= int'(VECS[i].ticks); t++) begin
                do_tick(v);
                dev = v - int'(VECS[i].n);
                if (VECS[i].f == 0)
                    check(dev == 0, rq, longint'(v), longint'(VECS[i].n));
                else
                    check(dev >= lo && dev <= hi, rq, longint'(dev), longint'(hi));
                cum  = cum + longint'(dev);
                base = (longint'(t) * longint'(VECS[i].f)) / longint'(VECS[i].m);
                check((cum - base) >= cum_lo(VECS[i].ord) && (cum - base) <= cum_hi(VECS[i].ord),
                      rq, cum - base, longint'(cum_hi(VECS[i].ord)));
                if (t == int'(VECS[i].m) && VECS[i].ord <= 2'd1)
                    check(cum == longint'(VECS[i].f), rq, cum, longint'(VECS[i].f));
            end
        end

        // R8: modulus change mid-sequence clears the accumulator.
        int_n = 16'd60; frac_num = 22'd3; modulus = 22'd51; order_sel = 2'd0;
        do_reset();
        for (int t = 0; t < 10; t++) do_tick(v);
        modulus = 22'd52;
        for (int t = 1; t <= 18; t++) begin
            do_tick(v);
            check(v == ((t == 18) ? 61 : 60), "R8", longint'(v), (t == 18) ? 61 : 60);
        end

        // R8: order change mid-sequence clears the accumulators.
        modulus = 22'd51; frac_num = 22'd3; order_sel = 2'd0;
        do_reset();
        for (int t = 0; t < 10; t++) do_tick(v);
        frac_num = 22'd0; order_sel = 2'd1;
        for (int t = 1; t <= 6; t++) begin
            do_tick(v);
            check(v == 60, "R8", longint'(v), 60);
        end

        // R9: integer part alone changes at once and keeps the residue.
        int_n = 16'd60; frac_num = 22'd3; modulus = 22'd51; order_sel = 2'd0;
        do_reset();
        for (int t = 0; t < 5; t++) do_tick(v);
        int_n = 16'd70;
        for (int t = 1; t <= 12; t++) begin
            do_tick(v);
            check(v == ((t == 12) ? 71 : 70), "R9", longint'(v), (t == 12) ? 71 : 70);
        end

        // R10: reset in the middle of a run clears output and state.
        do_reset();
        do_tick(v);
        check(v == 70, "R10", longint'(v), 70);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule